// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a small processor core. Software sees sixteen logical registers, R0 to R15. Behind them sit twenty-five physical storage words. The current two-bit processor mode decides which physical copy a logical register reaches. R0 to R9 and R15 are a single copy shared by every mode. R10 to R12 have one private copy for fast-interrupt mode and one shared copy for the other three modes. R13 and R14 have a separate copy in each of the four modes, which lets an interrupt handler use them without saving the interrupted code's values.

The mode is turned into five active-low bank selects. All register steering uses only these selects, and the selects are also driven out so they can be observed. A block-transfer instruction that has its S bit set, and that drives bus B, must reach the user registers whatever the current mode is. Instruction decode supplies three lines for this case: a block-transfer flag, the S bit and an active-low bus-B enable. When all three are active, the block uses the user-mode bank for both read ports and for the write port. The selects it drives out show the user bank during such an access.

The block has two combinational read ports and one write port, which is clocked on the rising edge. A synchronous active-high reset clears every physical word.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, all 25 physical words are cleared to zero, so every logical register in every mode reads zero afterwards.
- R2: R0–R9 and R15 are one physical word each, shared by all modes: a value written in any mode reads back in every mode.
- R3: R10–R12 reach a private copy in fast-interrupt mode (`mode` = 01). In modes 00, 10 and 11 they reach a single shared copy.
- R4: R13–R14 reach a separate copy in each mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor). A write in one mode leaves the other three modes' copies unchanged.
- R5: `bank_sel_n` bits are {bit4 user, bit3 supervisor, bit2 interrupt, bit1 fast interrupt, bit0 general}, all active low. Without override, mode 00 gives 01110, 01 gives 11101, 10 gives 11010 and 11 gives 10110.
- R6: Exactly one of `bank_sel_n[4:1]` is low at all times, and exactly one of `bank_sel_n[1:0]` is low.
- R7: When `blk_xfer`=1, `s_bit`=1 and `busb_en_n`=0, reads and writes use the user-mode mapping and `bank_sel_n` equals 01110, whatever `mode` is.
- R8: If any one of those three override conditions is missing, the mapping and `bank_sel_n` follow `mode`.
- R9: A write takes effect at the rising edge only when `wr_en` is high. With `wr_en` low, no register changes.
- R10: The two read ports are combinational and independent. Each returns the register selected by its own address under the current mapping in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Processor mode: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor |
| blk_xfer | input | 1 | Decode flag: a block-transfer instruction is active |
| s_bit | input | 1 | S bit of the instruction |
| busb_en_n | input | 1 | Bus-B enable, active low |
| rd_a_addr | input | 4 | Logical address, read port A |
| rd_a_data | output | DATA_W | Data, read port A |
| rd_b_addr | input | 4 | Logical address, read port B |
| rd_b_data | output | DATA_W | Data, read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Logical address, write port |
| wr_data | input | DATA_W | Write data |
| bank_sel_n | output | 5 | Active-low bank selects {user, supervisor, interrupt, fast interrupt, general} |

## Verification
The bench builds the block with `DATA_W` = 8. Every value it writes is unique, so it encodes the mode and the register that produced it, and an aliasing error between any two of the 25 words shows up as a wrong byte. With eight-bit data, a full sweep of all four modes against all sixteen logical addresses on both read ports stays small. So does a check of all eight combinations of the override lines in each mode. Together these cover every path through the bank mapping and every bank-select pattern.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int LOG_REGS   = 16;
    localparam int PHYS_REGS  = 25;
    localparam int LADDR_W    = $clog2(LOG_REGS);
    localparam int PADDR_W    = $clog2(PHYS_REGS);
    localparam int BSEL_W     = 5;

    // first logical register that is banked in fast-interrupt mode
    localparam int FIQ_LO     = 10;
    // first logical register banked in every mode
    localparam int ALL_LO     = 13;
    localparam int ALL_HI     = 14;

    // physical placement of the private copies
    localparam int FIQ_BASE   = LOG_REGS;            // R10..R14 fast interrupt
    localparam int IRQ_BASE   = FIQ_BASE + 5;        // R13..R14 interrupt
    localparam int SVC_BASE   = IRQ_BASE + 2;        // R13..R14 supervisor

    typedef enum logic [1:0] {
        MODE_USR = 2'b00,
        MODE_FIQ = 2'b01,
        MODE_IRQ = 2'b10,
        MODE_SVC = 2'b11
    } cpu_mode_e;

    // active-low selects, bit order matters for the output port
    typedef struct packed {
        logic user_n;
        logic svc_n;
        logic irq_n;
        logic fiq_n;
        logic gen_n;
    } bank_sel_t;

    typedef logic [LADDR_W-1:0] laddr_t;
    typedef logic [PADDR_W-1:0] paddr_t;

    function automatic bank_sel_t decode_mode(cpu_mode_e m);
        bank_sel_t s;
        s.user_n = (m != MODE_USR);
        s.svc_n  = (m != MODE_SVC);
        s.irq_n  = (m != MODE_IRQ);
        s.fiq_n  = (m != MODE_FIQ);
        s.gen_n  = (m == MODE_FIQ);
        return s;
    endfunction

    function automatic paddr_t offs(laddr_t a, int base, int lo);
        return paddr_t'(base + (int'(a) - lo));
    endfunction

endpackage

// File: rtl/bank_select_gen.sv
module bank_select_gen
    import bankreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cpu_mode_e mode,
    input  logic      blk_xfer,
    input  logic      s_bit,
    input  logic      busb_en_n,
    output bank_sel_t sel,
    output logic      user_force
);

    cpu_mode_e eff_mode;

    always_comb begin
        user_force = blk_xfer & s_bit & ~busb_en_n;
        eff_mode   = user_force ? MODE_USR : mode;
        sel        = decode_mode(eff_mode);
    end

    // R6
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sel.user_n, sel.svc_n, sel.irq_n, sel.fiq_n}) == 3);

    // R6
    gen_fiq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        sel.gen_n != sel.fiq_n);

    // R7
    ovr_user_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_xfer && s_bit && !busb_en_n) |-> (!sel.user_n && !sel.gen_n));

endmodule

// File: rtl/reg_addr_map.sv
module reg_addr_map
    import bankreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  laddr_t    laddr,
    input  bank_sel_t sel,
    output paddr_t    paddr
);

    logic mid_bank;   // R10..R12
    logic top_bank;   // R13..R14

    always_comb begin
        mid_bank = (int'(laddr) >= FIQ_LO) && (int'(laddr) < ALL_LO);
        top_bank = (int'(laddr) >= ALL_LO) && (int'(laddr) <= ALL_HI);
        paddr    = paddr_t'(laddr);
        if (mid_bank) begin
            // only the general / fast-interrupt pair decides here
            if (!sel.gen_n)
                paddr = paddr_t'(laddr);
            else
                paddr = offs(laddr, FIQ_BASE, FIQ_LO);
        end else if (top_bank) begin
            unique case ({sel.user_n, sel.svc_n, sel.irq_n, sel.fiq_n})
                4'b0111: paddr = paddr_t'(laddr);
                4'b1110: paddr = offs(laddr, FIQ_BASE, FIQ_LO);
                4'b1101: paddr = offs(laddr, IRQ_BASE, ALL_LO);
                4'b1011: paddr = offs(laddr, SVC_BASE, ALL_LO);
                default: paddr = paddr_t'(laddr);
            endcase
        end
    end

    // R4
    paddr_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(paddr) < PHYS_REGS);

endmodule

// File: rtl/bank_storage.sv
module bank_storage
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  paddr_t            waddr,
    input  logic [DATA_W-1:0] wdata,
    input  paddr_t            raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  paddr_t            raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] words [PHYS_REGS];

    generate
        for (genvar i = 0; i < PHYS_REGS; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    words[i] <= '0;
                else if (we && (int'(waddr) == i))
                    words[i] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata_a = (int'(raddr_a) < PHYS_REGS) ? words[raddr_a] : '0;
        rdata_b = (int'(raddr_b) < PHYS_REGS) ? words[raddr_b] : '0;
    end

    // R9
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !$past(rst) && int'(waddr) < PHYS_REGS) |=> (words[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              blk_xfer,
    input  logic              s_bit,
    input  logic              busb_en_n,
    input  logic [3:0]        rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [4:0]        bank_sel_n
);

    localparam int NPORTS = 3;   // read A, read B, write

    bank_sel_t sel_s;
    logic      user_force;
    laddr_t    map_in  [NPORTS];
    paddr_t    map_out [NPORTS];

    bank_select_gen u_sel (
        .clk        (clk),
        .rst        (rst),
        .mode       (cpu_mode_e'(mode)),
        .blk_xfer   (blk_xfer),
        .s_bit      (s_bit),
        .busb_en_n  (busb_en_n),
        .sel        (sel_s),
        .user_force (user_force)
    );

    assign map_in[0] = rd_a_addr;
    assign map_in[1] = rd_b_addr;
    assign map_in[2] = wr_addr;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_map
            reg_addr_map u_map (
                .clk   (clk),
                .rst   (rst),
                .laddr (map_in[p]),
                .sel   (sel_s),
                .paddr (map_out[p])
            );
        end
    endgenerate

    bank_storage #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (map_out[2]),
        .wdata   (wr_data),
        .raddr_a (map_out[0]),
        .rdata_a (rd_a_data),
        .raddr_b (map_out[1]),
        .rdata_b (rd_b_data)
    );

    assign bank_sel_n = sel_s;

    // R2
    unbanked_map_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr < 4'd10 || rd_a_addr == 4'd15) |-> (map_out[0] == paddr_t'(rd_a_addr)));

    // R7
    force_map_chk: assert property (@(posedge clk) disable iff (rst)
        (user_force && wr_addr < 4'd10) |-> (map_out[2] == paddr_t'(wr_addr)));

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode;
    logic          blk_xfer, s_bit, busb_en_n;
    logic [3:0]    rd_a_addr, rd_b_addr, wr_addr;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
    logic          wr_en;
    logic [4:0]    bank_sel_n;

    int checks = 0;
    int errors = 0;
    int model [25];

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .blk_xfer(blk_xfer), .s_bit(s_bit),
        .busb_en_n(busb_en_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .bank_sel_n(bank_sel_n)
    );

    function automatic int pidx(int m, int r);
        if (r < 10 || r == 15) return r;
        if (r < 13) return (m == 1) ? 16 + (r - 10) : r;
        case (m)
            0: return r;
            1: return 16 + (r - 10);
            2: return 21 + (r - 13);
            default: return 23 + (r - 13);
        endcase
    endfunction

    function automatic logic [4:0] esel(int m);
        return {m != 0, m != 3, m != 2, m != 1, m == 1};
    endfunction

    function automatic string rtag(int r);
        if (r < 10 || r == 15) return "R2";
        if (r < 13) return "R3";
        return "R4";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input int m, input int ov);
        mode      = 2'(m);
        blk_xfer  = ov[0];
        s_bit     = ov[1];
        busb_en_n = ov[2];
    endtask

    task automatic do_write(input int m, input int ov, input int r, input int d);
        @(negedge clk);
        set_ctl(m, ov);
        wr_addr = 4'(r);
        wr_data = DW'(d);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model[pidx((ov == 3) ? 0 : m, r)] = d & 8'hFF;
    endtask

    task automatic read_pair(input int m, input int ov, input int ra, input int rb, input string tag);
        int em;
        set_ctl(m, ov);
        rd_a_addr = 4'(ra);
        rd_b_addr = 4'(rb);
        #1;
        em = (ov == 3) ? 0 : m;
        chk(tag, int'(rd_a_data), model[pidx(em, ra)]);
        chk({tag, "/R10"}, int'(rd_b_data), model[pidx(em, rb)]);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        set_ctl(0, 0);
        foreach (model[i]) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state in every mode
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 16; r++)
                read_pair(m, 0, r, 15 - r, "R1");

        // R5 R6 R7 R8: bank selects over all modes and override lines
        for (int m = 0; m < 4; m++)
            for (int ov = 0; ov < 8; ov++) begin
                set_ctl(m, ov);
                #1;
                chk((ov == 3) ? "R7" : ((ov == 0) ? "R5/R6" : "R8"),
                    int'(bank_sel_n), int'(esel((ov == 3) ? 0 : m)));
            end

        // unique values from every mode into every register
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 16; r++)
                do_write(m, 0, r, m * 16 + r + 1);

        // R2 R3 R4 R10: full read sweep
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 16; r++)
                read_pair(m, 0, r, (r * 7 + 3) % 16, rtag(r));

        // R7 R8: override on writes and reads of banked registers
        for (int m = 1; m < 4; m++)
            for (int ov = 0; ov < 8; ov++) begin
                do_write(m, ov, 13, 8'hA0 + m * 8 + ov);
                read_pair(m, 0, 13, 14, (ov == 3) ? "R7" : "R8");
                read_pair(0, 0, 13, 11, (ov == 3) ? "R7" : "R8");
                read_pair(m, ov, 14, 13, (ov == 3) ? "R7" : "R8");
            end

        // R9: write enable low changes nothing
        @(negedge clk);
        set_ctl(2, 0);
        for (int r = 0; r < 16; r++) begin
            wr_addr = 4'(r);
            wr_data = 8'hEE;
            wr_en   = 1'b0;
            @(negedge clk);
            read_pair(2, 0, r, r, "R9");
        end

        // R1: reset again after data is present
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        foreach (model[i]) model[i] = 0;
        for (int m = 0; m < 4; m++)
            for (int r = 10; r < 15; r++)
                read_pair(m, 0, r, r - 10, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule